// File: doc/BRIEF.md
# Bit-Serial Dongle Register Access Master

This block is a sequencer that reads and writes indexed registers inside an external infrared transceiver dongle over a two-wire clocked serial link. It drives a serial clock line and a data-out line, and it watches one input line that the dongle uses first as a ready indication and then to return read data. The host side presents a single request holding a 7-bit device address, a register index, the transfer direction and, for writes, one data byte. The block runs the whole exchange on its own and then reports completion with a one-cycle done pulse, the byte read back and a not-ready flag.

Every pulse on the serial clock is a low phase of `LO_CYC` system clock cycles followed by a high phase of `HI_CYC` cycles. The data line may change only at the start of a low phase. A read first polls the dongle for readiness for a bounded number of pulses and ends with a fixed trailer of pulses. A separate request type produces the long burst of clock pulses that resets the dongle. The block does not interpret the contents of the dongle's registers.

Top module: `dongle_serial_master`

## Requirements
- R1: After reset, sck_o, sdo_o, busy_o, done_o and not_ready_o are 0 and rd_data_o is 0.
- R2: Each serial clock pulse is LO_CYC cycles low followed by HI_CYC cycles high (defaults 3 and 2), and sdo_o never changes while sck_o stays high.
- R3: A read or write starts with one pulse carrying data 0, then sends the command byte least significant bit first; the command byte is the zero-extended address ORed with the index shifted left by one, with bit 0 then forced to 1 for a write and 0 for a read.
- R4: A write sends the data byte least significant bit first after the command, then two pulses carrying data 0, for 19 rising edges in all, and leaves both lines low.
- R5: After the read command the block issues up to POLL_MAX (10) pulses carrying data 1; sdi_i is sampled on the system clock edge that ends each high phase, and polling stops at the first pulse whose sample is 0.
- R6: Once ready is seen, 8 further pulses carrying data 1 are issued and sdi_i is sampled at the end of each high phase, the first sample becoming rd_data_o bit 0.
- R7: If all POLL_MAX samples are 1, two extra pulses carrying data 1 follow, and the completion reports not_ready_o = 1 with rd_data_o = 0 (25 rising edges in all).
- R8: Every read finishes with one pulse carrying data 1 and then three pulses carrying data 0, leaving both lines low.
- R9: A request with req_reset = 1 produces exactly 30 pulses carrying data 0 and then leaves the clock low; req_reset takes priority over req_write.
- R10: busy_o is 1 from the cycle after an accepted request until completion; done_o is a single-cycle pulse with busy_o already 0; a request presented while busy_o is 1 is ignored and not queued.
- R11: rd_data_o and not_ready_o change only at completion and hold until the next one; a write or reset completion sets both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when busy_o is 0 |
| req_write | input | 1 | 1 for a register write, 0 for a read |
| req_reset | input | 1 | 1 requests the dongle reset burst |
| req_addr | input | 7 | Device address |
| req_index | input | IDX_W | Register index within the device |
| req_wdata | input | 8 | Byte to write |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 8 | Byte returned by the last read |
| not_ready_o | output | 1 | Last read timed out waiting for ready |
| sck_o | output | 1 | Serial clock to the dongle |
| sdo_o | output | 1 | Serial data to the dongle |
| sdi_i | input | 1 | Ready and read data from the dongle |

## Verification
The assertions assume the host holds the request fields steady only in the cycle req_valid is high and that sdi_i is a synchronous level, already stable in the cycle that ends each high phase. The bench's dongle model meets this by changing sdi_i on the falling system clock edge just after it sees the serial clock rise, which with the default HI_CYC of 2 leaves a full cycle before the sample. Requests are driven on falling edges, and one extra request is deliberately thrown in mid-transfer to show it is dropped.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LEAD,
    ST_CMD,
    ST_WDATA,
    ST_WTAIL,
    ST_POLL,
    ST_RDATA,
    ST_DUMMY,
    ST_RTAIL_HI,
    ST_RTAIL_LO,
    ST_RSTB,
    ST_FINAL
  } seq_state_t;

endpackage

// File: rtl/dsm_phase_timer.sv
module dsm_phase_timer #(
  parameter int LO_CYC = 3,
  parameter int HI_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic hi,
  output logic last
);
  localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  assign last = run && (cnt == (hi ? CW'(HI_CYC - 1) : CW'(LO_CYC - 1)));

  always_ff @(posedge clk) begin
    if (rst || !run || last) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(MAXC));

endmodule

// File: rtl/dsm_rx_capture.sv
module dsm_rx_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst || clr) data <= '0;
    else if (shift) data <= {bit_in, data[W-1:1]};
  end
endmodule

// File: rtl/dongle_serial_master.sv
module dongle_serial_master
  import dsm_pkg::*;
#(
  parameter int IDX_W        = 3,
  parameter int LO_CYC       = 3,
  parameter int HI_CYC       = 2,
  parameter int POLL_MAX     = 10,
  parameter int RESET_PULSES = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_reset,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [IDX_W-1:0]   req_index,
  input  logic [BYTE_W-1:0]  req_wdata,
  output logic               busy_o,
  output logic               done_o,
  output logic [BYTE_W-1:0]  rd_data_o,
  output logic               not_ready_o,
  output logic               sck_o,
  output logic               sdo_o,
  input  logic               sdi_i
);
  localparam int BIGGEST = (RESET_PULSES > POLL_MAX) ? RESET_PULSES : POLL_MAX;
  localparam int CNT_W   = $clog2(BIGGEST + BYTE_W + 1);

  seq_state_t        state;
  logic              hi;
  logic              last;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] wdata_q;
  logic              is_read;
  logic              nr_pend;
  logic [BYTE_W-1:0] rx_data;
  logic [BYTE_W-1:0] cmd_w;
  logic              accept;
  logic              pulse_end;

  always_comb begin
    cmd_w    = {{(BYTE_W-ADDR_W){1'b0}}, req_addr} |
               {{(BYTE_W-1-IDX_W){1'b0}}, req_index, 1'b0};
    cmd_w[0] = req_write;
  end

  assign accept    = (state == ST_IDLE) && req_valid;
  assign pulse_end = last && hi;

  dsm_phase_timer #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (state != ST_IDLE),
    .hi   (hi),
    .last (last)
  );

  dsm_rx_capture #(.W(BYTE_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .shift  (pulse_end && (state == ST_RDATA)),
    .bit_in (sdi_i),
    .data   (rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      hi          <= 1'b0;
      cnt         <= '0;
      sh          <= '0;
      wdata_q     <= '0;
      is_read     <= 1'b0;
      nr_pend     <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      rd_data_o   <= '0;
      not_ready_o <= 1'b0;
      sck_o       <= 1'b0;
      sdo_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            busy_o  <= 1'b1;
            hi      <= 1'b0;
            sck_o   <= 1'b0;
            sdo_o   <= 1'b0;
            cnt     <= '0;
            nr_pend <= 1'b0;
            sh      <= cmd_w;
            wdata_q <= req_wdata;
            is_read <= !req_reset && !req_write;
            state   <= req_reset ? ST_RSTB : ST_LEAD;
          end
        end
        ST_FINAL: begin
          if (last) begin
            state  <= ST_IDLE;
            busy_o <= 1'b0;
            done_o <= 1'b1;
            if (is_read) begin
              rd_data_o   <= nr_pend ? '0 : rx_data;
              not_ready_o <= nr_pend;
            end else begin
              rd_data_o   <= '0;
              not_ready_o <= 1'b0;
            end
          end
        end
        default: begin
          if (last && !hi) begin
            hi    <= 1'b1;
            sck_o <= 1'b1;
          end else if (pulse_end) begin
            hi    <= 1'b0;
            sck_o <= 1'b0;
            cnt   <= cnt + 1'b1;
            case (state)
              ST_LEAD: begin
                state <= ST_CMD;
                cnt   <= '0;
                sdo_o <= sh[0];
              end
              ST_CMD: begin
                if (cnt == CNT_W'(BYTE_W - 1)) begin
                  cnt <= '0;
                  if (is_read) begin
                    state <= ST_POLL;
                    sdo_o <= 1'b1;
                  end else begin
                    state <= ST_WDATA;
                    sh    <= wdata_q;
                    sdo_o <= wdata_q[0];
                  end
                end else begin
                  sh    <= sh >> 1;
                  sdo_o <= sh[1];
                end
              end
              ST_WDATA: begin
                if (cnt == CNT_W'(BYTE_W - 1)) begin
                  state <= ST_WTAIL;
                  cnt   <= '0;
                  sdo_o <= 1'b0;
                end else begin
                  sh    <= sh >> 1;
                  sdo_o <= sh[1];
                end
              end
              ST_WTAIL: begin
                sdo_o <= 1'b0;
                if (cnt == CNT_W'(1)) state <= ST_FINAL;
              end
              ST_POLL: begin
                sdo_o <= 1'b1;
                if (!sdi_i) begin
                  state <= ST_RDATA;
                  cnt   <= '0;
                end else if (cnt == CNT_W'(POLL_MAX - 1)) begin
                  state   <= ST_DUMMY;
                  cnt     <= '0;
                  nr_pend <= 1'b1;
                end
              end
              ST_RDATA: begin
                sdo_o <= 1'b1;
                if (cnt == CNT_W'(BYTE_W - 1)) begin
                  state <= ST_RTAIL_HI;
                  cnt   <= '0;
                end
              end
              ST_DUMMY: begin
                sdo_o <= 1'b1;
                if (cnt == CNT_W'(1)) begin
                  state <= ST_RTAIL_HI;
                  cnt   <= '0;
                end
              end
              ST_RTAIL_HI: begin
                state <= ST_RTAIL_LO;
                cnt   <= '0;
                sdo_o <= 1'b0;
              end
              ST_RTAIL_LO: begin
                sdo_o <= 1'b0;
                if (cnt == CNT_W'(2)) state <= ST_FINAL;
              end
              ST_RSTB: begin
                sdo_o <= 1'b0;
                if (cnt == CNT_W'(RESET_PULSES - 1)) state <= ST_FINAL;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // Data line is only moved while the serial clock is low.
  assert_sdo_quiet_high_R2: assert property (@(posedge clk) disable iff (rst)
    (sck_o && $past(sck_o)) |-> $stable(sdo_o));

  // Both lines rest low whenever no transfer runs.
  assert_idle_lines_low_R4: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!sck_o && !sdo_o));

  // Busy can only drop together with the completion pulse.
  assert_busy_drop_done_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_nready_zero_R7: assert property (@(posedge clk) disable iff (rst)
    not_ready_o |-> (rd_data_o == '0));

  // Outputs toward the host only move at completion.
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(rd_data_o) && $stable(not_ready_o)));

endmodule

// File: tb/dongle_serial_master_bench.sv
module dongle_serial_master_bench;

  localparam int IDX_W = 3;
  localparam int LO    = 3;
  localparam int HI    = 2;
  localparam int WD    = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0, req_reset = 1'b0;
  logic [6:0] req_addr = '0;
  logic [IDX_W-1:0] req_index = '0;
  logic [7:0] req_wdata = '0;
  logic       busy_o, done_o, not_ready_o, sck_o, sdo_o;
  logic [7:0] rd_data_o;
  logic       sdi_i = 1'b1;

  int errors = 0;
  int checks = 0;

  dongle_serial_master #(.IDX_W(IDX_W), .LO_CYC(LO), .HI_CYC(HI)) u_dongle_serial_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_reset(req_reset), .req_addr(req_addr), .req_index(req_index),
    .req_wdata(req_wdata), .busy_o(busy_o), .done_o(done_o),
    .rd_data_o(rd_data_o), .not_ready_o(not_ready_o), .sck_o(sck_o),
    .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  always #2.5 clk = ~clk;

  // Dongle model and line monitor
  int          edges = 0;
  logic [63:0] stream = '0;
  int          r2_viol = 0;
  int          hi_run = 0, lo_run = 0, hi_bad = 0, lo_bad = 0;
  logic        psck = 1'b0, psdo = 1'b0;
  logic        rd_mode = 1'b0;
  int          rd_k = 0;
  logic [7:0]  rd_val = '0;
  int          cyc = 0;
  logic        wd_hit = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cyc > WD) wd_hit = 1'b1;
    if (sck_o && !psck) begin
      edges = edges + 1;
      if (edges <= 64) stream[edges-1] = sdo_o;
      if (edges > 1 && lo_run != LO) lo_bad = lo_bad + 1;
      hi_run = 0;
      if (rd_mode) begin
        if (rd_k <= 10 && edges >= 10 + rd_k && edges <= 17 + rd_k)
          sdi_i = rd_val[edges-10-rd_k];
        else if (edges >= 10 && edges <= 19 && (edges - 9) >= rd_k)
          sdi_i = 1'b0;
        else
          sdi_i = 1'b1;
      end else sdi_i = 1'b1;
    end
    if (!sck_o && psck && hi_run != HI) hi_bad = hi_bad + 1;
    if (sck_o) hi_run = hi_run + 1; else hi_run = 0;
    if (!sck_o) lo_run = (sck_o != psck) ? 1 : lo_run + 1;
    if (sck_o && psck && sdo_o != psdo) r2_viol = r2_viol + 1;
    psck = sck_o;
    psdo = sdo_o;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd_of(input logic [6:0] a, input logic [IDX_W-1:0] i, input logic w);
    logic [7:0] c;
    c = {1'b0, a} | ({5'b0, i} << 1);
    c[0] = w;
    return c;
  endfunction

  task automatic clear_mon();
    @(negedge clk);
    edges = 0; stream = '0; r2_viol = 0; hi_bad = 0; lo_bad = 0;
  endtask

  task automatic issue(input logic w, input logic r, input logic [6:0] a,
                       input logic [IDX_W-1:0] i, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_reset = r;
    req_addr = a; req_index = i; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 busy after accept", busy_o, 1'b1);
  endtask

  task automatic wait_done();
    while (!done_o && !wd_hit) @(negedge clk);
    if (wd_hit) check("watchdog", 1, 0);
  endtask

  task automatic finish_checks(input string tag, input int n, input logic [63:0] exp);
    logic [63:0] mask;
    mask = (64'd1 << n) - 1;
    check({tag, " edge count"}, edges, n);
    check({tag, " data stream"}, stream & mask, exp);
    check("R2 sdo stable while high", r2_viol, 0);
    check("R2 phase lengths", hi_bad + lo_bad, 0);
    check("R10 busy low with done", busy_o, 1'b0);
    @(negedge clk);
    check("R10 done single pulse", done_o, 1'b0);
    check("R4 clock low after end", sck_o, 1'b0);
  endtask

  task automatic t_reset_state();
    check("R1 sck", sck_o, 0);
    check("R1 sdo", sdo_o, 0);
    check("R1 busy/done", {busy_o, done_o}, 0);
    check("R1 results", {not_ready_o, rd_data_o}, 0);
  endtask

  task automatic t_write(input logic [6:0] a, input logic [IDX_W-1:0] i, input logic [7:0] d);
    logic [63:0] exp;
    clear_mon();
    rd_mode = 1'b0;
    exp = {45'b0, 2'b00, d, cmd_of(a, i, 1'b1), 1'b0};
    issue(1'b1, 1'b0, a, i, d);
    wait_done();
    check("R11 write clears results", {not_ready_o, rd_data_o}, 0);
    finish_checks("R3 R4 write", 19, exp);
  endtask

  task automatic t_read(input logic [6:0] a, input logic [IDX_W-1:0] i, input int k, input logic [7:0] v);
    logic [63:0] exp;
    int n;
    clear_mon();
    rd_mode = 1'b1; rd_k = k; rd_val = v;
    exp = '0;
    exp[8:0] = {cmd_of(a, i, 1'b0), 1'b0};
    if (k <= 10) begin
      n = 9 + k + 8 + 4;
      for (int b = 9; b < 9 + k + 8 + 1; b++) exp[b] = 1'b1;
    end else begin
      n = 25;
      for (int b = 9; b < 22; b++) exp[b] = 1'b1;
    end
    issue(1'b0, 1'b0, a, i, 8'h00);
    wait_done();
    if (k <= 10) begin
      check("R6 read data", rd_data_o, v);
      check("R5 ready flag", not_ready_o, 1'b0);
    end else begin
      check("R7 not ready flag", not_ready_o, 1'b1);
      check("R7 zero data", rd_data_o, 8'h00);
    end
    finish_checks("R5 R8 read", n, exp);
    rd_mode = 1'b0;
  endtask

  task automatic t_dongle_reset();
    clear_mon();
    issue(1'b1, 1'b1, 7'h40, 3'd1, 8'hFF);
    wait_done();
    check("R9 reset clears results", {not_ready_o, rd_data_o}, 0);
    finish_checks("R9 reset burst", 30, 64'd0);
  endtask

  task automatic t_ignore_busy();
    logic [63:0] exp;
    clear_mon();
    rd_mode = 1'b0;
    exp = {45'b0, 2'b00, 8'h3C, cmd_of(7'h20, 3'd2, 1'b1), 1'b0};
    issue(1'b1, 1'b0, 7'h20, 3'd2, 8'h3C);
    repeat (12) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_reset = 1'b1; req_addr = 7'h7F;
    @(negedge clk);
    req_valid = 1'b0; req_reset = 1'b0;
    wait_done();
    finish_checks("R10 ignored request", 19, exp);
    repeat (40) @(negedge clk);
    check("R10 request not queued", {busy_o, edges}, {1'b0, 32'd19});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_write(7'h40, 3'd1, 8'hA5);
    t_write(7'h40, 3'd2, 8'h17);
    t_read(7'h40, 3'd1, 3, 8'hC6);
    t_read(7'h41, 3'd0, 1, 8'h5A);
    t_read(7'h40, 3'd7, 10, 8'h81);
    t_read(7'h40, 3'd3, 11, 8'h00);
    t_read(7'h40, 3'd4, 2, 8'h3B);
    t_dongle_reset();
    t_ignore_busy();
    if (wd_hit) check("watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (wd_hit);
    repeat (2) @(negedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule